// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts a programmed number of seconds down to zero and then raises an alarm. Software writes a 32-bit seconds value into a load register; each one-cycle pulse on the second-tick input takes one off the remaining count while the run bit is set. When a tick moves the count from one to zero, a sticky pending flag is set and the counter stays at zero.

The pending flag drives two outputs. An interrupt line is the flag masked by an interrupt-enable bit. A wakeup line is the flag masked by a wakeup-enable bit. Software clears the flag by writing one to its status bit. The recommended reprogramming order is: clear the run bit, load zero, load the new count, then set the run bit. The tick source and whatever consumes the wakeup line sit outside the block.

The register bus is a simple single-cycle request port. A write takes effect at the clock edge where the request is presented. Read data is registered and appears one cycle after the read request. Word index = address bits [4:2]:

| Index | Register | Access |
|---|---|---|
| 0 | load value | read/write |
| 1 | remaining count | read only |
| 2 | run | bit 0 |
| 3 | interrupt enable | bit 0 |
| 4 | status (pending) | bit 0, write one to clear |
| 5 | wakeup enable | bit 0 |

Top module: `sec_alarm_top`

## Requirements
- R1: After reset, every register reads zero, and both the interrupt and the wakeup outputs are low.
- R2: A write to index 0 stores the value for readback and sets the remaining count (index 1) to that value at the same edge, whether or not the run bit is set.
- R3: A tick with the run bit set and a nonzero count lowers the count by exactly one. With the run bit clear, a tick leaves the count unchanged.
- R4: A zero count stays zero under further ticks, and those ticks set no pending flag. Loading zero clears the count.
- R5: The pending flag (index 4, bit 0) sets on the tick that takes the count from one to zero while running. It then stays set until it is cleared.
- R6: Writing 1 to index 4 bit 0 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R7: When a pending-set event and a clear write fall in the same cycle, the flag ends up set.
- R8: The interrupt output is high exactly when the pending flag and the interrupt-enable bit (index 3, bit 0) are both set.
- R9: The wakeup output is high exactly when the pending flag and the wakeup-enable bit (index 5, bit 0) are both set.
- R10: The control registers at indices 2, 3 and 5 keep only bit 0, and their other bits read zero. Writes to index 1 are ignored. Read data appears one cycle after the read request.
- R11: A load write in the same cycle as a running tick sets the count to the loaded value, and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte address; bits [4:2] select the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
The assertions assume two things about the inputs: the tick is a single-cycle pulse, and each bus request lasts exactly one cycle with the address already aligned to a word. Under those assumptions, the count either steps down by one, reloads, or holds, and the pending flag can rise only on a one-to-zero step. The stimulus tasks always drive the tick and the requests on the falling edge and release them one cycle later. They combine tick, load and clear only in the cycles where a collision case is being tested on purpose.

// File: rtl/sec_alarm_pkg.sv
// Package: shared register-index encoding and bus width for the seconds alarm.
// Assumes a word-addressed map selected by address bits [4:2].
package sec_alarm_pkg;
    localparam int BUS_W = 32;
    localparam int IDX_W = 3;
    localparam int IDX_LSB = 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_LOAD    = 3'd0,
        IDX_REMAIN  = 3'd1,
        IDX_RUN     = 3'd2,
        IDX_IRQ_EN  = 3'd3,
        IDX_STATUS  = 3'd4,
        IDX_WAKE_EN = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/sec_alarm_regs.sv
// Module: register file and bus decode for the seconds alarm.
// It holds the load value and the three single-bit controls, and it decodes the
// load write and the status clear strobes. Read data is registered.
// Assumes: single-cycle requests, and ADDR_W large enough to cover the index bits.
module sec_alarm_regs
    import sec_alarm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BUS_W-1:0]  req_wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              pend_i,
    output logic              load_wr_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              clr_o,
    output logic              run_o,
    output logic              irq_en_o,
    output logic              wake_en_o,
    output logic [BUS_W-1:0]  rdata_o
);
    localparam int NUM_CTRL = 3;
    localparam logic [IDX_W-1:0] CTRL_IDX [NUM_CTRL] = '{IDX_RUN, IDX_IRQ_EN, IDX_WAKE_EN};

    logic [IDX_W-1:0] idx;
    logic             wr_en;
    logic             rd_en;
    logic [CNT_W-1:0] load_q;
    logic [NUM_CTRL-1:0] ctrl_q;
    logic [BUS_W-1:0] rd_mux;

    // Decode the word index and the access type.
    always_comb begin
        idx   = req_addr_i[IDX_LSB +: IDX_W];
        wr_en = req_valid_i && req_write_i;
        rd_en = req_valid_i && !req_write_i;
    end

    // Produce the strobes that the counter and the flag consume.
    always_comb begin
        load_wr_o  = wr_en && (idx == IDX_LOAD);
        load_val_o = req_wdata_i[CNT_W-1:0];
        clr_o      = wr_en && (idx == IDX_STATUS) && req_wdata_i[0];
    end

    // Keep the last loaded value for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)         load_q <= '0;
        else if (load_wr_o) load_q <= req_wdata_i[CNT_W-1:0];
    end

    // One flop per single-bit control register.
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n)                             ctrl_q[g] <= 1'b0;
            else if (wr_en && idx == CTRL_IDX[g])   ctrl_q[g] <= req_wdata_i[0];
        end
    end

    assign run_o     = ctrl_q[0];
    assign irq_en_o  = ctrl_q[1];
    assign wake_en_o = ctrl_q[2];

    // Select the readback word for the addressed register.
    always_comb begin
        case (idx)
            IDX_LOAD:    rd_mux = BUS_W'(load_q);
            IDX_REMAIN:  rd_mux = BUS_W'(cnt_i);
            IDX_RUN:     rd_mux = BUS_W'(ctrl_q[0]);
            IDX_IRQ_EN:  rd_mux = BUS_W'(ctrl_q[1]);
            IDX_STATUS:  rd_mux = BUS_W'(pend_i);
            IDX_WAKE_EN: rd_mux = BUS_W'(ctrl_q[2]);
            default:     rd_mux = '0;
        endcase
    end

    // Register read data on a read request, and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_o <= '0;
        else if (rd_en) rdata_o <= rd_mux;
    end
endmodule

// File: rtl/sec_alarm_counter.sv
// Module: down-counter of remaining seconds.
// A load write sets the count at once and takes priority over a tick. A running
// tick on a nonzero count subtracts one. The expire strobe marks the 1->0 step.
// Assumes tick_i is a single-cycle pulse.
module sec_alarm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic step;

    // Decide whether this cycle decrements the count.
    always_comb begin
        step     = tick_i && run_i && (cnt_o != '0) && !load_wr_i;
        expire_o = step && (cnt_o == CNT_W'(1));
    end

    // Count register: load first, then decrement, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_o <= '0;
        else if (load_wr_i) cnt_o <= load_val_i;
        else if (step)      cnt_o <= cnt_o - CNT_W'(1);
    end
endmodule

// File: rtl/sec_alarm_flag.sv
// Module: sticky pending flag, plus the masked interrupt and wakeup outputs.
// A set and a clear in the same cycle leave the flag set.
// Assumes clr_i is already qualified with the written data bit.
module sec_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    input  logic wake_en_i,
    output logic pend_o,
    output logic irq_o,
    output logic wake_o
);
    // Pending flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    // Mask the flag onto the two request lines.
    always_comb begin
        irq_o  = pend_o && irq_en_i;
        wake_o = pend_o && wake_en_i;
    end
endmodule

// File: rtl/sec_alarm_top.sv
// Module: seconds countdown alarm top level.
// It connects the register file, the down-counter and the pending flag.
// Assumes: tick_i is a one-cycle pulse, and bus requests last one cycle.
module sec_alarm_top
    import sec_alarm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BUS_W-1:0]  req_wdata_i,
    output logic [BUS_W-1:0]  rsp_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic             load_wr;
    logic [CNT_W-1:0] load_val;
    logic             clr;
    logic             run_q;
    logic             irq_en_q;
    logic             wake_en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             pend_q;

    sec_alarm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .req_addr_i (req_addr_i),
        .req_wdata_i(req_wdata_i),
        .cnt_i      (cnt_q),
        .pend_i     (pend_q),
        .load_wr_o  (load_wr),
        .load_val_o (load_val),
        .clr_o      (clr),
        .run_o      (run_q),
        .irq_en_o   (irq_en_q),
        .wake_en_o  (wake_en_q),
        .rdata_o    (rsp_rdata_o)
    );

    sec_alarm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run_q),
        .load_wr_i (load_wr),
        .load_val_i(load_val),
        .cnt_o     (cnt_q),
        .expire_o  (expire)
    );

    sec_alarm_flag flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (expire),
        .clr_i    (clr),
        .irq_en_i (irq_en_q),
        .wake_en_i(wake_en_q),
        .pend_o   (pend_q),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );
endmodule

// File: rtl/sec_alarm_checker.sv
// Checker: temporal properties of the seconds alarm, bound into the top level.
// Assumes single-cycle tick pulses and single-cycle bus requests.
module sec_alarm_checker
    import sec_alarm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [BUS_W-1:0]  req_wdata_i,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              pend,
    input logic              irq_en,
    input logic              wake_en,
    input logic              irq_o,
    input logic              wake_o
);
    logic ld_wr;
    logic st_clr;
    assign ld_wr  = req_valid_i && req_write_i && (req_addr_i[IDX_LSB +: IDX_W] == IDX_LOAD);
    assign st_clr = req_valid_i && req_write_i && (req_addr_i[IDX_LSB +: IDX_W] == IDX_STATUS)
                    && req_wdata_i[0];

    a_r2_load_sets_count: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> cnt == $past(req_wdata_i[CNT_W-1:0]));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run && cnt != '0 && !ld_wr) |=> cnt == $past(cnt) - CNT_W'(1));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_wr) |=> $stable(cnt));

    a_r4_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !ld_wr) |=> cnt == '0);

    a_r5_rise_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick_i && run && cnt == CNT_W'(1) && !ld_wr));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !st_clr) |=> pend);

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run && cnt == CNT_W'(1) && !ld_wr) |=> pend);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && irq_en));

    a_r9_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (pend && wake_en));
endmodule

bind sec_alarm_top sec_alarm_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .cnt        (cnt_q),
    .run        (run_q),
    .pend       (pend_q),
    .irq_en     (irq_en_q),
    .wake_en    (wake_en_q),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
);

// File: tb/sec_alarm_top_tb_top.sv
// Directed bench for the seconds alarm: one task per scenario.
module sec_alarm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rv = 1'b0;
    logic        rw = 1'b0;
    logic [4:0]  ra = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;
    logic        wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [4:0] A_LOAD = 5'd0, A_REM = 5'd4, A_RUN = 5'd8,
                           A_IE = 5'd12, A_ST = 5'd16, A_WE = 5'd20;

    always #2.5 clk = ~clk;

    sec_alarm_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .req_valid_i(rv), .req_write_i(rw), .req_addr_i(ra), .req_wdata_i(wd),
        .rsp_rdata_o(rd), .irq_o(irq), .wake_o(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); rv = 1; rw = 1; ra = a; wd = d;
        @(negedge clk); rv = 0; rw = 0;
    endtask

    task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); rv = 1; rw = 0; ra = a;
        @(negedge clk); rv = 0;
        check(req, rd, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    // R1: reset values.
    task automatic t_reset();
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 wake", {31'd0, wake}, 0);
        rdchk("R1 load", A_LOAD, 0);
        rdchk("R1 remain", A_REM, 0);
        rdchk("R1 status", A_ST, 0);
        rdchk("R1 run", A_RUN, 0);
    endtask

    // R2, R3, R10: loading and stepping.
    task automatic t_load_step();
        wr(A_LOAD, 5);
        rdchk("R2 load readback", A_LOAD, 5);
        rdchk("R2 remain", A_REM, 5);
        ticks(2);
        rdchk("R3 stopped hold", A_REM, 5);
        wr(A_RUN, 32'hFFFF_FFFF);
        rdchk("R10 run bit only", A_RUN, 1);
        ticks(2);
        rdchk("R3 decrement", A_REM, 3);
        wr(A_REM, 99);
        rdchk("R10 remain read-only", A_REM, 3);
        wr(A_LOAD, 0);
        rdchk("R4 load zero clears", A_REM, 0);
        ticks(2);
        rdchk("R4 zero stays", A_REM, 0);
        rdchk("R4 no pend at zero", A_ST, 0);
    endtask

    // R2, R5, R8, R9, R6: expiry and outputs.
    task automatic t_expire();
        wr(A_IE, 1);
        wr(A_LOAD, 3);
        rdchk("R2 reload while running", A_REM, 3);
        ticks(2);
        rdchk("R5 not yet", A_ST, 0);
        check("R8 irq low before", {31'd0, irq}, 0);
        ticks(1);
        rdchk("R5 remain zero", A_REM, 0);
        rdchk("R5 pending set", A_ST, 1);
        check("R8 irq high", {31'd0, irq}, 1);
        check("R9 wake low", {31'd0, wake}, 0);
        ticks(2);
        rdchk("R5 sticky", A_ST, 1);
        wr(A_WE, 1);
        check("R9 wake high", {31'd0, wake}, 1);
        wr(A_IE, 0);
        check("R8 irq masked", {31'd0, irq}, 0);
        wr(A_ST, 0);
        rdchk("R6 write zero no effect", A_ST, 1);
        wr(A_ST, 1);
        rdchk("R6 clear", A_ST, 0);
        check("R9 wake low after clear", {31'd0, wake}, 0);
    endtask

    // R7 and R11: same-cycle collisions.
    task automatic t_collide();
        wr(A_LOAD, 1);
        @(negedge clk); tick = 1; rv = 1; rw = 1; ra = A_ST; wd = 1;
        @(negedge clk); tick = 0; rv = 0; rw = 0;
        rdchk("R7 set beats clear", A_ST, 1);
        wr(A_ST, 1);
        wr(A_LOAD, 10);
        @(negedge clk); tick = 1; rv = 1; rw = 1; ra = A_LOAD; wd = 7;
        @(negedge clk); tick = 0; rv = 0; rw = 0;
        rdchk("R11 load beats tick", A_REM, 7);
        rdchk("R11 no pend", A_ST, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_step();
        t_expire();
        t_collide();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule